// File: doc/BRIEF.md
# Masked Associative Segment Translator

The block maps a 23-bit logical address onto a physical address by searching a small table of segment descriptors. Every descriptor is checked in parallel. Each one holds a compare pattern, a mask count, a physical base, a valid flag and a read-only flag. The mask count gives the number of low address bits that the compare skips. As a result, segments of different power-of-two sizes sit side by side in the same table. When a descriptor matches, the address bits at and above the mask count are replaced by the matching base. The bits below the mask count pass through as the offset.

A lookup is requested with a one-cycle strobe, and the result appears registered on the next cycle. The result is exactly one of three outcomes: hit, miss or protection fault. A miss tells system software to load a descriptor. Software writes a whole descriptor into any slot it chooses through a single-cycle refill port. The hardware does not walk tables and does not choose which slot to replace.

Top module: `seg_xlate_top`

## Requirements
- R1: After reset every descriptor is invalid, so every lookup misses until a refill. While reset is held, and on the first cycle after it, all response outputs are 0.
- R2: A request sampled with `req_vld`=1 on a clock edge produces `rsp_vld`=1 on the next cycle. With no request, `rsp_vld`, `rsp_hit`, `rsp_miss`, `rsp_prot`, `rsp_multi`, `rsp_idx` and `rsp_paddr` are all 0.
- R3: A descriptor matches only when its valid flag is 1 and the address bits at and above its mask count k equal the same bits of its compare pattern. An invalid descriptor never matches.
- R4: On a hit, bit i of `rsp_paddr` (24 bits) is the base bit i for i >= k, and the logical address bit i for i < k.
- R5: A mask count above 23 behaves as 23. Such a descriptor matches every address, and `rsp_paddr` is {base bit 23, logical address}.
- R6: When no descriptor matches, `rsp_miss`=1, `rsp_hit`=0, `rsp_prot`=0, `rsp_multi`=0, `rsp_idx`=0 and `rsp_paddr`=0. On every response exactly one of hit, miss and protection fault is 1.
- R7: When several descriptors match, the lowest-numbered one decides the outcome and is reported on `rsp_idx`. `rsp_multi` is 1 whenever two or more descriptors match.
- R8: A write lookup (`req_wr`=1) that selects a read-only descriptor gives `rsp_prot`=1, `rsp_hit`=0, `rsp_paddr`=0 and the descriptor index on `rsp_idx`. Read lookups on read-only descriptors, and writes to writable descriptors, hit normally.
- R9: A refill updates the indexed slot in one clock. A lookup issued in the same cycle as the refill sees the old contents. A lookup one cycle later sees the new contents.
- R10: A refill with `ref_vld`=0 removes that slot from matching and leaves every other slot unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| req_vld | input | 1 | Lookup strobe |
| req_addr | input | 23 | Logical address |
| req_wr | input | 1 | Lookup is a write access |
| ref_en | input | 1 | Refill strobe |
| ref_idx | input | 5 | Slot to overwrite |
| ref_cmp | input | 23 | Compare pattern |
| ref_msk | input | 5 | Number of masked low bits |
| ref_base | input | 24 | Physical segment base |
| ref_vld | input | 1 | Valid flag of the new descriptor |
| ref_ro | input | 1 | Read-only flag of the new descriptor |
| rsp_vld | output | 1 | Response present |
| rsp_hit | output | 1 | Translation succeeded |
| rsp_miss | output | 1 | No descriptor matched |
| rsp_prot | output | 1 | Write to a read-only segment |
| rsp_multi | output | 1 | Two or more descriptors matched |
| rsp_idx | output | 5 | Selected descriptor |
| rsp_paddr | output | 24 | Physical address |

## Verification
The bench builds the block with its default parameters: 32 slots, a 23-bit logical address, a 24-bit physical address and a 5-bit mask count. At these values the top slot, index 31, can lose the priority race to slot 0. Mask counts from 0 up to 31 reach the clamp beyond the address width. Random descriptors with overlapping ranges bring multi-hit and protection cases within reach, alongside the directed same-cycle refill case.

// File: rtl/seg_xlate_pkg.sv
package seg_xlate_pkg;

    typedef enum logic [1:0] {
        RES_NONE = 2'd0,
        RES_HIT  = 2'd1,
        RES_MISS = 2'd2,
        RES_PROT = 2'd3
    } res_kind_e;

    // effective number of masked bits, never beyond the address width
    function automatic int unsigned clamp_k(input int unsigned msk, input int unsigned lim);
        return (msk > lim) ? lim : msk;
    endfunction

endpackage

// File: rtl/seg_xlate_table.sv
module seg_xlate_table #(
    parameter int N_ENT = 32,
    parameter int LA_W  = 23,
    parameter int PA_W  = 24,
    parameter int SZ_W  = 5,
    parameter int IDX_W = 5
) (
    input  logic                             clk,
    input  logic                             rst_n,
    input  logic                             wr_en,
    input  logic [IDX_W-1:0]                 wr_idx,
    input  logic [LA_W-1:0]                  wr_cmp,
    input  logic [SZ_W-1:0]                  wr_msk,
    input  logic [PA_W-1:0]                  wr_base,
    input  logic                             wr_vld,
    input  logic                             wr_ro,
    output logic [N_ENT-1:0]                 ent_vld,
    output logic [N_ENT-1:0]                 ent_ro,
    output logic [N_ENT-1:0][LA_W-1:0]       ent_cmp,
    output logic [N_ENT-1:0][SZ_W-1:0]       ent_msk,
    output logic [N_ENT-1:0][PA_W-1:0]       ent_base
);

    typedef struct packed {
        logic [N_ENT-1:0]           vld;
        logic [N_ENT-1:0]           ro;
        logic [N_ENT-1:0][LA_W-1:0] cmp;
        logic [N_ENT-1:0][SZ_W-1:0] msk;
        logic [N_ENT-1:0][PA_W-1:0] base;
    } tbl_t;

    tbl_t tbl_d, tbl_q;

    always_comb begin
        tbl_d = tbl_q;
        if (wr_en && (int'(wr_idx) < N_ENT)) begin
            tbl_d.vld[wr_idx]  = wr_vld;
            tbl_d.ro[wr_idx]   = wr_ro;
            tbl_d.cmp[wr_idx]  = wr_cmp;
            tbl_d.msk[wr_idx]  = wr_msk;
            tbl_d.base[wr_idx] = wr_base;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            tbl_q <= '0;
        end else begin
            tbl_q <= tbl_d;
        end
    end

    assign ent_vld  = tbl_q.vld;
    assign ent_ro   = tbl_q.ro;
    assign ent_cmp  = tbl_q.cmp;
    assign ent_msk  = tbl_q.msk;
    assign ent_base = tbl_q.base;

endmodule

// File: rtl/seg_xlate_match.sv
module seg_xlate_match #(
    parameter int N_ENT = 32,
    parameter int LA_W  = 23,
    parameter int SZ_W  = 5
) (
    input  logic [LA_W-1:0]            la,
    input  logic [N_ENT-1:0]           ent_vld,
    input  logic [N_ENT-1:0][LA_W-1:0] ent_cmp,
    input  logic [N_ENT-1:0][SZ_W-1:0] ent_msk,
    output logic [N_ENT-1:0]           hit_vec
);
    import seg_xlate_pkg::*;

    for (genvar e = 0; e < N_ENT; e++) begin : g_ent
        logic [LA_W-1:0] hi_keep;
        always_comb begin
            hi_keep    = {LA_W{1'b1}} << clamp_k(int'(ent_msk[e]), LA_W);
            hit_vec[e] = ent_vld[e] && (((la ^ ent_cmp[e]) & hi_keep) == '0);
        end
    end

endmodule

// File: rtl/seg_xlate_prio.sv
module seg_xlate_prio #(
    parameter int N_ENT = 32,
    parameter int IDX_W = 5
) (
    input  logic [N_ENT-1:0]  hit_vec,
    output logic              any,
    output logic              multi,
    output logic [IDX_W-1:0]  win
);

    int unsigned cnt;

    always_comb begin
        win = '0;
        cnt = 0;
        for (int e = N_ENT - 1; e >= 0; e--) begin
            if (hit_vec[e]) begin
                win = IDX_W'(e);
                cnt = cnt + 1;
            end
        end
        any   = (cnt != 0);
        multi = (cnt > 1);
    end

endmodule

// File: rtl/seg_xlate_top.sv
module seg_xlate_top #(
    parameter  int N_ENT = 32,
    parameter  int LA_W  = 23,
    parameter  int PA_W  = 24,
    parameter  int SZ_W  = 5,
    localparam int IDX_W = (N_ENT > 1) ? $clog2(N_ENT) : 1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              req_vld,
    input  logic [LA_W-1:0]   req_addr,
    input  logic              req_wr,
    input  logic              ref_en,
    input  logic [IDX_W-1:0]  ref_idx,
    input  logic [LA_W-1:0]   ref_cmp,
    input  logic [SZ_W-1:0]   ref_msk,
    input  logic [PA_W-1:0]   ref_base,
    input  logic              ref_vld,
    input  logic              ref_ro,
    output logic              rsp_vld,
    output logic              rsp_hit,
    output logic              rsp_miss,
    output logic              rsp_prot,
    output logic              rsp_multi,
    output logic [IDX_W-1:0]  rsp_idx,
    output logic [PA_W-1:0]   rsp_paddr
);
    import seg_xlate_pkg::*;

    typedef struct packed {
        res_kind_e          kind;
        logic               multi;
        logic [IDX_W-1:0]   idx;
        logic [PA_W-1:0]    paddr;
    } rsp_t;

    logic [N_ENT-1:0]           ent_vld, ent_ro, hit_vec;
    logic [N_ENT-1:0][LA_W-1:0] ent_cmp;
    logic [N_ENT-1:0][SZ_W-1:0] ent_msk;
    logic [N_ENT-1:0][PA_W-1:0] ent_base;
    logic                       any_hit, multi_hit;
    logic [IDX_W-1:0]           win;
    logic [PA_W-1:0]            lo_keep;
    rsp_t                       rsp_d, rsp_q;

    seg_xlate_table #(
        .N_ENT(N_ENT), .LA_W(LA_W), .PA_W(PA_W), .SZ_W(SZ_W), .IDX_W(IDX_W)
    ) i_table (
        .clk(clk), .rst_n(rst_n),
        .wr_en(ref_en), .wr_idx(ref_idx), .wr_cmp(ref_cmp), .wr_msk(ref_msk),
        .wr_base(ref_base), .wr_vld(ref_vld), .wr_ro(ref_ro),
        .ent_vld(ent_vld), .ent_ro(ent_ro), .ent_cmp(ent_cmp),
        .ent_msk(ent_msk), .ent_base(ent_base)
    );

    seg_xlate_match #(
        .N_ENT(N_ENT), .LA_W(LA_W), .SZ_W(SZ_W)
    ) i_match (
        .la(req_addr), .ent_vld(ent_vld), .ent_cmp(ent_cmp),
        .ent_msk(ent_msk), .hit_vec(hit_vec)
    );

    seg_xlate_prio #(
        .N_ENT(N_ENT), .IDX_W(IDX_W)
    ) i_prio (
        .hit_vec(hit_vec), .any(any_hit), .multi(multi_hit), .win(win)
    );

    always_comb begin
        rsp_d   = '0;
        lo_keep = ~({PA_W{1'b1}} << clamp_k(int'(ent_msk[win]), LA_W));
        if (req_vld) begin
            if (!any_hit) begin
                rsp_d.kind = RES_MISS;
            end else begin
                rsp_d.multi = multi_hit;
                rsp_d.idx   = win;
                if (req_wr && ent_ro[win]) begin
                    rsp_d.kind = RES_PROT;
                end else begin
                    rsp_d.kind  = RES_HIT;
                    rsp_d.paddr = (ent_base[win] & ~lo_keep) |
                                  (PA_W'(req_addr) & lo_keep);
                end
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            rsp_q <= '0;
        end else begin
            rsp_q <= rsp_d;
        end
    end

    assign rsp_vld   = (rsp_q.kind != RES_NONE);
    assign rsp_hit   = (rsp_q.kind == RES_HIT);
    assign rsp_miss  = (rsp_q.kind == RES_MISS);
    assign rsp_prot  = (rsp_q.kind == RES_PROT);
    assign rsp_multi = rsp_q.multi;
    assign rsp_idx   = rsp_q.idx;
    assign rsp_paddr = rsp_q.paddr;

endmodule

// File: rtl/seg_xlate_chk.sv
module seg_xlate_chk #(
    parameter int IDX_W = 5,
    parameter int PA_W  = 24
) (
    input logic             clk,
    input logic             rst_n,
    input logic             req_vld,
    input logic             req_wr,
    input logic             rsp_vld,
    input logic             rsp_hit,
    input logic             rsp_miss,
    input logic             rsp_prot,
    input logic             rsp_multi,
    input logic [IDX_W-1:0] rsp_idx,
    input logic [PA_W-1:0]  rsp_paddr
);

    assert_reset_quiet_R1: assert property (@(posedge clk)
        !rst_n |=> (!rsp_vld && !rsp_multi && rsp_paddr == '0));

    assert_latency_R2: assert property (@(posedge clk) disable iff (!rst_n)
        req_vld |=> rsp_vld);

    assert_idle_R2: assert property (@(posedge clk) disable iff (!rst_n)
        !req_vld |=> (!rsp_vld && !rsp_hit && !rsp_miss && !rsp_prot &&
                      !rsp_multi && rsp_idx == '0 && rsp_paddr == '0));

    assert_one_outcome_R6: assert property (@(posedge clk) disable iff (!rst_n)
        rsp_vld |-> $countones({rsp_hit, rsp_miss, rsp_prot}) == 1);

    assert_miss_clean_R6: assert property (@(posedge clk) disable iff (!rst_n)
        rsp_miss |-> (!rsp_multi && rsp_idx == '0 && rsp_paddr == '0));

    assert_multi_needs_match_R7: assert property (@(posedge clk) disable iff (!rst_n)
        rsp_multi |-> (rsp_hit || rsp_prot));

    assert_prot_on_write_R8: assert property (@(posedge clk) disable iff (!rst_n)
        rsp_prot |-> ($past(req_wr) && rsp_paddr == '0));

endmodule

bind seg_xlate_top seg_xlate_chk #(
    .IDX_W(IDX_W), .PA_W(PA_W)
) i_chk (
    .clk(clk), .rst_n(rst_n), .req_vld(req_vld), .req_wr(req_wr),
    .rsp_vld(rsp_vld), .rsp_hit(rsp_hit), .rsp_miss(rsp_miss),
    .rsp_prot(rsp_prot), .rsp_multi(rsp_multi), .rsp_idx(rsp_idx),
    .rsp_paddr(rsp_paddr)
);

// File: tb/test_seg_xlate_top.sv
`timescale 1ns/1ps
module test_seg_xlate_top;

    localparam int N_ENT = 32;
    localparam int LA_W  = 23;
    localparam int PA_W  = 24;
    localparam int SZ_W  = 5;
    localparam int IDX_W = 5;

    logic              clk = 1'b0;
    logic              rst_n = 1'b0;
    logic              req_vld = 1'b0, req_wr = 1'b0;
    logic [LA_W-1:0]   req_addr = '0;
    logic              ref_en = 1'b0, ref_vld = 1'b0, ref_ro = 1'b0;
    logic [IDX_W-1:0]  ref_idx = '0;
    logic [LA_W-1:0]   ref_cmp = '0;
    logic [SZ_W-1:0]   ref_msk = '0;
    logic [PA_W-1:0]   ref_base = '0;
    logic              rsp_vld, rsp_hit, rsp_miss, rsp_prot, rsp_multi;
    logic [IDX_W-1:0]  rsp_idx;
    logic [PA_W-1:0]   rsp_paddr;

    always #2 clk = ~clk;

    seg_xlate_top i_seg_xlate_top (
        .clk(clk), .rst_n(rst_n), .req_vld(req_vld), .req_addr(req_addr),
        .req_wr(req_wr), .ref_en(ref_en), .ref_idx(ref_idx), .ref_cmp(ref_cmp),
        .ref_msk(ref_msk), .ref_base(ref_base), .ref_vld(ref_vld), .ref_ro(ref_ro),
        .rsp_vld(rsp_vld), .rsp_hit(rsp_hit), .rsp_miss(rsp_miss),
        .rsp_prot(rsp_prot), .rsp_multi(rsp_multi), .rsp_idx(rsp_idx),
        .rsp_paddr(rsp_paddr)
    );

    // bench model of the descriptor table
    logic            m_vld [N_ENT];
    logic            m_ro  [N_ENT];
    logic [LA_W-1:0] m_cmp [N_ENT];
    logic [SZ_W-1:0] m_msk [N_ENT];
    logic [PA_W-1:0] m_base[N_ENT];

    int n_chk = 0;
    int n_fail = 0;
    bit done = 1'b0;

    // expected response
    logic            e_vld, e_hit, e_miss, e_prot, e_multi;
    logic [IDX_W-1:0] e_idx;
    logic [PA_W-1:0] e_paddr;

    function automatic int eff_k(input logic [SZ_W-1:0] m);
        return (int'(m) > LA_W) ? LA_W : int'(m);
    endfunction

    function automatic bit ent_match(input int e, input logic [LA_W-1:0] a);
        int k = eff_k(m_msk[e]);
        if (!m_vld[e]) return 1'b0;
        for (int b = k; b < LA_W; b++)
            if (a[b] != m_cmp[e][b]) return 1'b0;
        return 1'b1;
    endfunction

    task automatic predict(input logic [LA_W-1:0] a, input logic wr);
        int cnt = 0;
        int first = -1;
        e_vld = 1'b1; e_hit = 1'b0; e_miss = 1'b0; e_prot = 1'b0;
        e_multi = 1'b0; e_idx = '0; e_paddr = '0;
        for (int e = 0; e < N_ENT; e++) begin
            if (ent_match(e, a)) begin
                cnt++;
                if (first < 0) first = e;
            end
        end
        if (cnt == 0) begin
            e_miss = 1'b1;
        end else begin
            e_multi = (cnt > 1);
            e_idx   = IDX_W'(first);
            if (wr && m_ro[first]) begin
                e_prot = 1'b1;
            end else begin
                e_hit = 1'b1;
                for (int b = 0; b < PA_W; b++)
                    e_paddr[b] = (b < eff_k(m_msk[first])) ? ((b < LA_W) ? a[b] : 1'b0)
                                                            : m_base[first][b];
            end
        end
    endtask

    task automatic check_rsp(input string tag);
        n_chk++;
        if (rsp_vld !== e_vld || rsp_hit !== e_hit || rsp_miss !== e_miss ||
            rsp_prot !== e_prot || rsp_multi !== e_multi || rsp_idx !== e_idx ||
            rsp_paddr !== e_paddr) begin
            n_fail++;
            $display("FAIL %s: act vld=%b hit=%b miss=%b prot=%b multi=%b idx=%0d pa=%h exp vld=%b hit=%b miss=%b prot=%b multi=%b idx=%0d pa=%h",
                     tag, rsp_vld, rsp_hit, rsp_miss, rsp_prot, rsp_multi, rsp_idx, rsp_paddr,
                     e_vld, e_hit, e_miss, e_prot, e_multi, e_idx, e_paddr);
        end
    endtask

    task automatic expect_idle();
        e_vld = 1'b0; e_hit = 1'b0; e_miss = 1'b0; e_prot = 1'b0;
        e_multi = 1'b0; e_idx = '0; e_paddr = '0;
    endtask

    task automatic set_refill(input int idx, input logic [LA_W-1:0] cmp, input logic [SZ_W-1:0] msk,
                              input logic [PA_W-1:0] base, input logic v, input logic ro);
        ref_en = 1'b1; ref_idx = IDX_W'(idx); ref_cmp = cmp; ref_msk = msk;
        ref_base = base; ref_vld = v; ref_ro = ro;
    endtask

    task automatic model_write();
        m_vld[ref_idx] = ref_vld; m_ro[ref_idx] = ref_ro; m_cmp[ref_idx] = ref_cmp;
        m_msk[ref_idx] = ref_msk; m_base[ref_idx] = ref_base;
    endtask

    // called at a negedge; leaves at the following negedge
    task automatic refill(input int idx, input logic [LA_W-1:0] cmp, input logic [SZ_W-1:0] msk,
                          input logic [PA_W-1:0] base, input logic v, input logic ro);
        set_refill(idx, cmp, msk, base, v, ro);
        @(posedge clk);
        @(negedge clk);
        model_write();
        ref_en = 1'b0;
    endtask

    task automatic lookup(input logic [LA_W-1:0] a, input logic wr, input string tag);
        req_vld = 1'b1; req_addr = a; req_wr = wr;
        predict(a, wr);
        @(posedge clk);
        @(negedge clk);
        req_vld = 1'b0; req_wr = 1'b0;
        check_rsp(tag);
    endtask

    function automatic logic [LA_W-1:0] addr_in(input int e);
        logic [LA_W-1:0] keep = {LA_W{1'b1}} << eff_k(m_msk[e]);
        logic [LA_W-1:0] r = LA_W'($urandom);
        return (m_cmp[e] & keep) | (r & ~keep);
    endfunction

    initial begin
        #(4 * 150000);
        if (!done) begin
            n_fail++;
            $display("FAIL watchdog: act running exp finished");
            $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
            $finish;
        end
    end

    initial begin
        int seed_init;
        seed_init = $urandom(32'd20240611);
        for (int e = 0; e < N_ENT; e++) begin
            m_vld[e] = 0; m_ro[e] = 0; m_cmp[e] = '0; m_msk[e] = '0; m_base[e] = '0;
        end

        // R1: outputs quiet during reset
        repeat (3) @(negedge clk);
        expect_idle();
        check_rsp("R1 reset outputs");
        rst_n = 1'b1;
        @(negedge clk);
        expect_idle();
        check_rsp("R1 after reset");
        for (int i = 0; i < 4; i++) lookup(LA_W'($urandom), i[0], "R1 empty table misses");

        // R2: no request gives all-zero response
        @(negedge clk);
        expect_idle();
        check_rsp("R2 idle");

        // R3/R4: 4 KiB segment, k = 12
        refill(3, 23'h12_3456, 5'd12, 24'hAB_C000, 1'b1, 1'b0);
        lookup(23'h12_3FFF, 1'b0, "R3 R4 hit in 4K segment");
        lookup(23'h12_4000, 1'b0, "R3 just above segment misses");
        lookup(23'h12_2FFF, 1'b0, "R3 just below segment misses");

        // R5: mask 31 treated as 23, matches everything
        refill(9, 23'h0, 5'd31, 24'h80_0000, 1'b1, 1'b0);
        lookup(23'h7F_FFFF, 1'b0, "R5 clamped mask hit");
        lookup(23'h12_3001, 1'b0, "R7 lower slot wins over clamped slot");

        // R8 protection
        refill(3, 23'h12_3456, 5'd12, 24'hAB_C000, 1'b1, 1'b1);
        lookup(23'h12_3010, 1'b1, "R8 write to read-only");
        lookup(23'h12_3010, 1'b0, "R8 read of read-only");
        lookup(23'h00_0010, 1'b1, "R8 write to writable");

        // R7: slot 31 vs slot 0
        refill(31, 23'h40_0000, 5'd20, 24'h00_0000, 1'b1, 1'b0);
        refill(0, 23'h40_0100, 5'd8, 24'hFF_FF00, 1'b1, 1'b0);
        lookup(23'h40_01A5, 1'b0, "R7 slot 0 beats slot 31");

        // R10: invalidating slot 0 hands the address to the next match
        refill(0, 23'h40_0100, 5'd8, 24'hFF_FF00, 1'b0, 1'b0);
        lookup(23'h40_01A5, 1'b0, "R10 invalidated slot skipped");
        lookup(23'h12_3020, 1'b0, "R10 other slots unchanged");

        // R9: refill and lookup in the same cycle see the old table
        set_refill(9, 23'h0, 5'd0, 24'h0, 1'b0, 1'b0);
        req_vld = 1'b1; req_addr = 23'h55_5555; req_wr = 1'b0;
        predict(23'h55_5555, 1'b0);
        @(posedge clk);
        @(negedge clk);
        model_write();
        ref_en = 1'b0; req_vld = 1'b0;
        check_rsp("R9 same-cycle lookup sees old");
        lookup(23'h55_5555, 1'b0, "R9 next-cycle lookup sees new");

        // random descriptors, then mixed random lookups
        for (int e = 0; e < N_ENT; e++)
            refill(e, LA_W'($urandom), SZ_W'($urandom_range(0, 31)), PA_W'($urandom),
                   ($urandom_range(0, 7) != 0), $urandom_range(0, 1) == 1);
        for (int i = 0; i < 2000; i++) begin
            int e = $urandom_range(0, N_ENT - 1);
            logic [LA_W-1:0] a = ($urandom_range(0, 3) == 0) ? LA_W'($urandom) : addr_in(e);
            if ($urandom_range(0, 9) == 0)
                refill(e, LA_W'($urandom), SZ_W'($urandom_range(4, 22)), PA_W'($urandom),
                       ($urandom_range(0, 5) != 0), $urandom_range(0, 1) == 1);
            lookup(a, $urandom_range(0, 1) == 1, "R3 R4 R6 R7 R8 random");
        end

        done = 1'b1;
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end

endmodule